// File: doc/BRIEF.md
# Two-Wire Thermometer Transaction Sequencer

This block is a bus master for a combined digital thermometer and real-time clock that sits on a two-wire open-drain serial bus. A host pulses one of two strobes. The block then runs a complete command sequence on the bus and reports the result. The host sees a busy flag, a one-cycle completion pulse and a 16-bit temperature word.

Internally a bit engine produces start, stop, byte-write and byte-read frames. Every frame is divided into quarter-bit phases of a programmable length. A sequencer above the engine walks a short list of steps for each kind of transaction and picks the next transaction from what it read back. The initialization sequence reads the configuration byte and rewrites it only when it differs. It then restarts the clock oscillator. A measurement triggers a conversion and reads the 16-bit temperature register. The temperature register is a signed fixed-point value: bit 15 is the sign, bits 14..7 are the integer part and bits 6..0 are the fraction.

The bus pins are modelled as pull-down enables: a 1 pulls the line low and a 0 releases it. The line state is read back through `sda_in`.

Top module: `twt_top`

## Requirements
- R1: After reset, and whenever `busy` is low, both `scl_pull` and `sda_pull` are 0, so both lines are released. After reset, `busy`, `done` and `temp` are 0.
- R2: A start condition is SDA falling while SCL is high. A stop condition is SDA rising while SCL is high. Every transaction begins with a start and ends with a stop.
- R3: Every transaction sends the write address 0x9E straight after its start. If that address gets no acknowledge (SDA high during the ninth SCL pulse), the start and the address are repeated until an acknowledge arrives.
- R4: Bytes go out most significant bit first. Each bit is set while SCL is low and is held through the SCL high pulse. Read data is sampled while SCL is high.
- R5: A 16-bit register read sends 0x9E, then the command byte, then a repeated start, then the read address 0x9F. It then reads the high byte, answering with an acknowledge (SDA low), and the low byte, answering with a no-acknowledge (SDA high), and ends with a stop. The value is high byte × 256 + low byte.
- R6: The init strobe first performs a 16-bit read with command 0xAC. If the high byte is not 0xE7, a write transaction follows: 0x9E, 0xAC, 0xE7, stop. If the high byte is 0xE7, no write is made.
- R7: Initialization ends with a transaction that sends 0x9E, 0xC0, 0x00, 0x00 and a stop.
- R8: The measure strobe sends 0x9E, 0xEE and a stop. It then performs a 16-bit read with command 0xAA and places the whole unmasked 16-bit value on `temp`.
- R9: `busy` is high from the cycle after an accepted strobe until the end of the sequence. `done` is high for exactly one cycle per sequence, and `busy` is low in that same cycle.
- R10: An init or measure strobe that arrives while `busy` is high is ignored. It causes no extra bus traffic and no extra `done` pulse.
- R11: `temp` changes only in the cycle in which a measurement's `done` is high. An initialization leaves `temp` unchanged.
- R12: During a transaction, every SCL high pulse lasts exactly 2 × QUARTER_CLKS clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Strobe: run the initialization sequence |
| meas_req | input | 1 | Strobe: run a temperature measurement |
| sda_in | input | 1 | Sensed level of the data line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| temp | output | 16 | Last measured temperature (signed, 7 fraction bits) |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |

## Verification
The device model on the bus refuses the write address twice before it acknowledges. A master that gave up, or that did not restart with a new start condition, would fail to write the configuration and would show the wrong count of start conditions. Initialization runs twice: once with a configuration byte that differs from the target and once with one that matches. A design that always rewrites, or never rewrites, changes the write count. Temperatures with the sign bit set and cleared, with all bits set and with a lone low bit are compared through a scoreboard. That comparison catches a swapped byte order, a lost bit, a wrong acknowledge on the last byte, or masking of the result. Strobes sent in the middle of a measurement must not add a conversion, a clock write or a completion pulse.

// File: rtl/twt_pkg.sv
package twt_pkg;
   localparam logic [7:0] ADDR_WR  = 8'h9E;
   localparam logic [7:0] ADDR_RD  = 8'h9F;
   localparam logic [7:0] CMD_CFG  = 8'hAC;
   localparam logic [7:0] CMD_CLK  = 8'hC0;
   localparam logic [7:0] CMD_CONV = 8'hEE;
   localparam logic [7:0] CMD_TEMP = 8'hAA;

   typedef enum logic [1:0] {OP_START, OP_STOP, OP_WR, OP_RD} bus_op_e;
   typedef enum logic [2:0] {FL_RDCFG, FL_WRCFG, FL_CLK, FL_CONV, FL_RDTMP} flow_e;

   typedef struct packed {
      bus_op_e    op;
      logic [7:0] data;
      logic       mack;   // drive acknowledge after a read byte
   } step_t;
endpackage

// File: rtl/twt_sync.sv
module twt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= '1;
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/twt_bit_engine.sv
module twt_bit_engine
   import twt_pkg::*;
#(
   parameter int QUARTER_CLKS = 250
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  step_t      step,
   input  logic       sda_s,
   output logic       done,
   output logic       ack,
   output logic [7:0] rx,
   output logic       scl_lvl,
   output logic       sda_lvl
);
   localparam int CW = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(QUARTER_CLKS - 1);
   localparam logic [3:0] BYTE_LAST = 4'd8;

   logic       active, released, mack;
   bus_op_e    op;
   logic [3:0] unit;
   logic [1:0] q;
   logic [CW-1:0] cnt;
   logic [7:0] tx_sh;
   logic       q_end, last_unit, lev_scl, lev_sda;

   assign q_end     = active && (cnt == CNT_LAST);
   assign last_unit = (op == OP_START || op == OP_STOP) ? 1'b1 : (unit == BYTE_LAST);

   // every frame unit is four quarters; SCL is high in the middle two
   always_comb begin
      lev_scl = released ? 1'b1 : scl_lvl;
      lev_sda = released ? 1'b1 : sda_lvl;
      if (active) begin
         lev_scl = (q == 2'd1) || (q == 2'd2);
         unique case (op)
            OP_START: lev_sda = (q < 2'd2);
            OP_STOP:  lev_sda = (q >= 2'd2);
            OP_WR:    lev_sda = (unit == BYTE_LAST) ? 1'b1 : tx_sh[7];
            OP_RD:    lev_sda = (unit == BYTE_LAST) ? ~mack : 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         released <= 1'b1;
         mack     <= 1'b0;
         op       <= OP_STOP;
         unit     <= '0;
         q        <= '0;
         cnt      <= '0;
         tx_sh    <= '0;
         rx       <= '0;
         ack      <= 1'b0;
         done     <= 1'b0;
         scl_lvl  <= 1'b1;
         sda_lvl  <= 1'b1;
      end else begin
         scl_lvl <= lev_scl;
         sda_lvl <= lev_sda;
         done    <= 1'b0;
         if (!active) begin
            if (start) begin
               active   <= 1'b1;
               released <= 1'b0;
               op       <= step.op;
               tx_sh    <= step.data;
               mack     <= step.mack;
               unit     <= '0;
               q        <= '0;
               cnt      <= '0;
            end
         end else if (q_end) begin
            cnt <= '0;
            q   <= q + 2'd1;
            if (q == 2'd2) begin
               if (op == OP_WR && unit == BYTE_LAST) ack <= ~sda_s;
               if (op == OP_RD && unit != BYTE_LAST) rx <= {rx[6:0], sda_s};
            end
            if (q == 2'd3) begin
               if (last_unit) begin
                  active   <= 1'b0;
                  done     <= 1'b1;
                  released <= (op == OP_STOP);
               end else begin
                  unit  <= unit + 4'd1;
                  tx_sh <= {tx_sh[6:0], 1'b0};
               end
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/twt_txn_seq.sv
module twt_txn_seq
   import twt_pkg::*;
#(
   parameter logic [7:0] CFG_VALUE = 8'hE7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_req,
   input  logic        meas_req,
   output logic        eng_start,
   output step_t       eng_step,
   input  logic        eng_done,
   input  logic        eng_ack,
   input  logic [7:0]  eng_rx,
   output logic        busy,
   output logic        done,
   output logic [15:0] temp
);
   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;
   localparam logic [3:0] ADDR_IDX = 4'd1;

   state_e     state;
   flow_e      flow;
   logic [3:0] idx;
   logic [7:0] hi, lo;

   function automatic step_t step_of(flow_e f, logic [3:0] i);
      step_t s;
      s = '{op: OP_STOP, data: 8'h00, mack: 1'b0};
      if (i == 4'd0)           s.op = OP_START;
      else if (i == ADDR_IDX)  s = '{op: OP_WR, data: ADDR_WR, mack: 1'b0};
      else begin
         unique case (f)
            FL_RDCFG, FL_RDTMP: begin
               case (i)
                  4'd2: s = '{op: OP_WR, data: (f == FL_RDCFG) ? CMD_CFG : CMD_TEMP, mack: 1'b0};
                  4'd3: s.op = OP_START;
                  4'd4: s = '{op: OP_WR, data: ADDR_RD, mack: 1'b0};
                  4'd5: s = '{op: OP_RD, data: 8'h00, mack: 1'b1};
                  4'd6: s = '{op: OP_RD, data: 8'h00, mack: 1'b0};
                  default: ;
               endcase
            end
            FL_WRCFG: begin
               if (i == 4'd2)      s = '{op: OP_WR, data: CMD_CFG, mack: 1'b0};
               else if (i == 4'd3) s = '{op: OP_WR, data: CFG_VALUE, mack: 1'b0};
            end
            FL_CLK: begin
               if (i == 4'd2)                   s = '{op: OP_WR, data: CMD_CLK, mack: 1'b0};
               else if (i == 4'd3 || i == 4'd4) s = '{op: OP_WR, data: 8'h00, mack: 1'b0};
            end
            FL_CONV: begin
               if (i == 4'd2) s = '{op: OP_WR, data: CMD_CONV, mack: 1'b0};
            end
            default: ;
         endcase
      end
      return s;
   endfunction

   assign eng_step  = step_of(flow, idx);
   assign eng_start = (state == S_ISSUE);
   assign busy      = (state != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         flow  <= FL_RDCFG;
         idx   <= '0;
         hi    <= '0;
         lo    <= '0;
         temp  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: begin
               idx <= '0;
               if (init_req) begin
                  flow  <= FL_RDCFG;
                  state <= S_ISSUE;
               end else if (meas_req) begin
                  flow  <= FL_CONV;
                  state <= S_ISSUE;
               end
            end
            S_ISSUE: state <= S_WAIT;
            S_WAIT: if (eng_done) begin
               state <= S_ISSUE;
               if (idx == ADDR_IDX && !eng_ack) begin
                  idx <= '0;               // address refused: new start
               end else if (eng_step.op == OP_STOP) begin
                  idx <= '0;
                  unique case (flow)
                     FL_RDCFG: flow <= (hi == CFG_VALUE) ? FL_CLK : FL_WRCFG;
                     FL_WRCFG: flow <= FL_CLK;
                     FL_CONV:  flow <= FL_RDTMP;
                     FL_CLK: begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                     end
                     FL_RDTMP: begin
                        temp  <= {hi, lo};
                        state <= S_IDLE;
                        done  <= 1'b1;
                     end
                     default: state <= S_IDLE;
                  endcase
               end else begin
                  if (eng_step.op == OP_RD) begin
                     if (eng_step.mack) hi <= eng_rx;
                     else               lo <= eng_rx;
                  end
                  idx <= idx + 4'd1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/twt_top.sv
module twt_top
   import twt_pkg::*;
#(
   parameter int         QUARTER_CLKS = 250,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [7:0] CFG_VALUE    = 8'hE7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init_req,
   input  logic        meas_req,
   input  logic        sda_in,
   output logic        busy,
   output logic        done,
   output logic [15:0] temp,
   output logic        scl_pull,
   output logic        sda_pull
);
   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("twt_top: SYNC_STAGES out of range");
      assert (QUARTER_CLKS >= SYNC_STAGES + 2)
         else $error("twt_top: QUARTER_CLKS too small for input sampling");
   end

   logic       sda_s, eng_start, eng_done, eng_ack, scl_lvl, sda_lvl;
   logic [7:0] eng_rx;
   step_t      eng_step;

   twt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
   );

   twt_bit_engine #(.QUARTER_CLKS(QUARTER_CLKS)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .step(eng_step),
      .sda_s(sda_s), .done(eng_done), .ack(eng_ack), .rx(eng_rx),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
   );

   twt_txn_seq #(.CFG_VALUE(CFG_VALUE)) u_seq (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .meas_req(meas_req),
      .eng_start(eng_start), .eng_step(eng_step), .eng_done(eng_done),
      .eng_ack(eng_ack), .eng_rx(eng_rx), .busy(busy), .done(done),
      .temp(temp)
   );

   assign scl_pull = ~scl_lvl;
   assign sda_pull = ~sda_lvl;
endmodule

// File: rtl/twt_chk.sv
module twt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        init_req,
   input logic        meas_req,
   input logic        busy,
   input logic        done,
   input logic [15:0] temp,
   input logic        scl_pull,
   input logic        sda_pull
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R11
   temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(temp));

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_pull && !sda_pull));

   // R10
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(init_req || meas_req));
endmodule

bind twt_top twt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .init_req(init_req), .meas_req(meas_req),
   .busy(busy), .done(done), .temp(temp), .scl_pull(scl_pull),
   .sda_pull(sda_pull)
);

// File: tb/tb_twt_top.sv
module tb_twt_top;
   localparam int Q = 4;

   logic clk = 1'b0, rst_n = 1'b0, init_req = 1'b0, meas_req = 1'b0;
   logic busy, done, scl_pull, sda_pull, sda_in;
   logic [15:0] temp;
   always #5 clk = ~clk;

   twt_top #(.QUARTER_CLKS(Q), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .meas_req(meas_req),
      .sda_in(sda_in), .busy(busy), .done(done), .temp(temp),
      .scl_pull(scl_pull), .sda_pull(sda_pull)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- device model on the bus ----------------
   logic s_pull = 1'b0;
   logic scl, sda;
   assign scl = ~scl_pull;
   assign sda = ~(sda_pull | s_pull);
   assign sda_in = sda;

   logic p_scl = 1'b1, p_sda = 1'b1;
   logic dead = 1'b1, in_txn = 1'b0, rdmode = 1'b0, acked = 1'b0, macked = 1'b0, go_rd = 1'b0;
   logic [7:0] sh = 0, txb = 0, cmd = 0, clk_ptr = 0, cfg_hi = 0;
   logic [15:0] rword = 0, temp_reg = 0;
   logic [1:0] mack_log = 0;
   int bitn = 0, nbyte = 0, rb = 0, nack_left = 0;
   int start_n = 0, stop_n = 0, cfg_wr = 0, clk_wr = 0, conv_n = 0;
   int cyc = 0, rise_t = 0, pulses = 0, bad_width = 0;
   bit track = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (scl && p_scl && p_sda && !sda) begin
         in_txn = 1; dead = 0; rdmode = 0; bitn = 0; nbyte = 0; s_pull = 0; start_n++;
      end else if (scl && p_scl && !p_sda && sda) begin
         in_txn = 0; dead = 1; s_pull = 0; stop_n++;
      end else if (scl && !p_scl) begin
         if (in_txn) begin track = 1; rise_t = cyc; end
         if (!dead) begin
            if (!rdmode && bitn < 8) sh = {sh[6:0], sda};
            if (rdmode && bitn == 8) macked = !sda;
            bitn++;
         end
      end else if (!scl && p_scl) begin
         if (track) begin
            pulses++;
            if (cyc - rise_t != 2 * Q) bad_width++;
            track = 0;
         end
         if (!dead && !rdmode) begin
            if (bitn == 8) begin
               acked = 1; go_rd = 0;
               if (nbyte == 0) begin
                  if (sh == 8'h9E && nack_left > 0) begin nack_left--; acked = 0; end
                  else if (sh == 8'h9F) go_rd = 1;
                  else if (sh != 8'h9E) acked = 0;
               end else if (nbyte == 1) begin
                  cmd = sh;
                  if (sh == 8'hEE) conv_n++;
               end else if (nbyte == 2) begin
                  if (cmd == 8'hAC) begin cfg_hi = sh; cfg_wr++; end
                  if (cmd == 8'hC0) clk_ptr = sh;
               end else if (nbyte == 3) begin
                  if (cmd == 8'hC0 && clk_ptr == 8'h00 && sh == 8'h00) clk_wr++;
               end
               s_pull = acked;
            end else if (bitn == 9) begin
               s_pull = 0; bitn = 0; nbyte++;
               if (!acked) dead = 1;
               else if (go_rd) begin
                  rdmode = 1; rb = 0;
                  rword = (cmd == 8'hAC) ? {cfg_hi, 8'h5A} : temp_reg;
                  txb = rword[15:8];
                  s_pull = !txb[7];
               end
            end
         end else if (!dead && rdmode) begin
            if (bitn < 8) s_pull = !txb[7-bitn];
            else if (bitn == 8) s_pull = 0;
            else begin
               mack_log = {mack_log[0], macked};
               bitn = 0;
               if (macked && rb == 0) begin
                  rb = 1; txb = rword[7:0]; s_pull = !txb[7];
               end else begin
                  dead = 1; s_pull = 0;
               end
            end
         end
      end
      p_scl = scl; p_sda = sda;
   end

   // ---------------- scoreboard ----------------
   logic [16:0] exp_q[$];
   int done_seen = 0;

   always @(negedge clk) begin
      if (rst_n && done) begin
         done_seen++;
         chk(!busy, "R9 busy low with done", busy, 0);
         if (exp_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
         else begin
            logic [16:0] e;
            e = exp_q.pop_front();
            // R8 R5 R4: full 16-bit value, high byte first, MSB first
            if (e[16]) chk(temp == e[15:0], "R8 temperature", temp, e[15:0]);
         end
      end
   end

   task automatic strobe(input bit is_meas);
      @(negedge clk);
      if (is_meas) meas_req = 1; else init_req = 1;
      @(negedge clk);
      meas_req = 0; init_req = 0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_init();
      exp_q.push_back({1'b0, 16'h0});
      strobe(0);
      wait_done();
   endtask

   task automatic run_meas(input logic [15:0] v);
      int c0, s0, d0;
      c0 = conv_n; s0 = stop_n; d0 = done_seen;
      temp_reg = v;
      exp_q.push_back({1'b1, v});
      strobe(1);
      wait_done();
      chk(conv_n == c0 + 1, "R8 one conversion", conv_n - c0, 1);
      chk(mack_log == 2'b10, "R5 ack high byte, nack low byte", mack_log, 2'b10);
      chk(stop_n == s0 + 2, "R2 two stops per measurement", stop_n - s0, 2);
      chk(done_seen == d0 + 1, "R9 single done", done_seen - d0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int s0, w0, k0, c0;
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
      chk(temp == 0, "R1 temp after reset", temp, 0);
      chk(!scl_pull && !sda_pull, "R1 lines released", {scl_pull, sda_pull}, 0);

      // init with mismatching config and two refused addresses
      cfg_hi = 8'h00; nack_left = 2;
      run_init();
      chk(nack_left == 0, "R3 refusals consumed", nack_left, 0);
      chk(start_n == 6, "R3 start retried", start_n, 6);
      chk(cfg_hi == 8'hE7 && cfg_wr == 1, "R6 config rewritten", {cfg_hi, cfg_wr[7:0]}, 16'hE701);
      chk(clk_wr == 1, "R7 clock halt cleared", clk_wr, 1);
      chk(stop_n == 3, "R2 stop per transaction", stop_n, 3);
      chk(!scl_pull && !sda_pull, "R1 released after init", {scl_pull, sda_pull}, 0);
      chk(temp == 0, "R11 init leaves temp", temp, 0);

      // init with matching config: no rewrite
      s0 = start_n; w0 = cfg_wr; k0 = clk_wr;
      run_init();
      chk(cfg_wr == w0, "R6 no rewrite when equal", cfg_wr - w0, 0);
      chk(clk_wr == k0 + 1, "R7 clock write again", clk_wr - k0, 1);
      chk(start_n == s0 + 3, "R3 no retry when acked", start_n - s0, 3);

      // measurements over several patterns
      run_meas(16'h0C80);
      run_meas(16'hF380);
      run_meas(16'hFFFF);
      run_meas(16'h8000);
      run_meas(16'h0001);
      run_meas(16'h7F3A);

      // R11 hold
      held = temp;
      repeat (40) @(negedge clk);
      chk(temp == held, "R11 temp holds", temp, held);

      // R10 strobes while busy
      c0 = conv_n; k0 = clk_wr; s0 = start_n;
      temp_reg = 16'h1234;
      exp_q.push_back({1'b1, 16'h1234});
      strobe(1);
      repeat (30) @(negedge clk);
      strobe(0);
      repeat (200) @(negedge clk);
      strobe(1);
      wait_done();
      repeat (60) @(negedge clk);
      chk(!busy, "R10 no restart after busy strobes", busy, 0);
      chk(conv_n == c0 + 1 && clk_wr == k0, "R10 no extra traffic", conv_n - c0, 1);
      chk(start_n == s0 + 3, "R10 start count", start_n - s0, 3);
      chk(exp_q.size() == 0, "R10 no extra done", exp_q.size(), 0);

      // R12 SCL pulse width
      chk(pulses > 100 && bad_width == 0, "R12 SCL high width", bad_width, 0);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule